// File: doc/BRIEF.md
# Registered-Busy Pipeline Link with Receiver Skid Buffer

This block joins a sending pipeline stage to a receiving stage that can be stalled from further downstream. The packet crossing the link is a decoded micro-operation: a valid qualifier, a fault flag, a reorder tag, an opcode, a destination register, two source registers and an immediate. Backpressure toward the sender is a busy flag held in a flip-flop. The sender therefore learns about a stall one clock edge late, and one more packet can already be on its way when the stall begins.

The sender side places each accepted packet in a channel register. While it sees busy, it leaves that register unchanged. The receiver side looks at the channel on every cycle. It forwards a fresh packet downstream, or parks it in a one-entry skid buffer if downstream is stalled. It raises busy for as long as that buffer is occupied. The packet that was in flight when busy started is kept in the still-held channel register. The receiver passes it on only after the parked packet has gone. Because the receiver owns this buffering, the sender needs no retry copy, and stalls cost one cycle less than they would under a retry scheme.

Both stream edges follow valid/ready rules. Upstream, a packet is taken on a clock edge where `up_valid` and `up_ready` are both high. The upstream data is ignored whenever `up_ready` is low. Downstream, `dn_valid` and `dn_uop` are held steady until `dn_ready` is seen high. The `up_ready` pin is the busy flag that the sender sees, inverted.

Top module: `busy_skid_link`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `dn_valid` is 0 and `up_ready` is 1.
- R2: While `dn_ready` stays high, `up_ready` never drops. Each accepted packet appears on `dn_uop` with `dn_valid` high in the cycle right after the edge that accepted it.
- R3: `up_ready` falls only in the cycle after one in which `dn_valid` was high and `dn_ready` was low. It stays low while downstream keeps stalling with a packet parked.
- R4: While `up_ready` is low, the values on `up_valid` and `up_uop` are ignored: nothing presented in those cycles is ever delivered.
- R5: Starting from an empty link with `dn_ready` held low and a continuous upstream supply, exactly two packets are accepted: the one that stalls, and the one in flight while busy becomes visible. Both are delivered later.
- R6: Packets leave in acceptance order, each exactly once. A parked packet leaves before any packet behind it.
- R7: A cycle with `up_valid` low produces no output and occupies no buffer. Bubbles against a stalled downstream leave `up_ready` high and `dn_valid` low.
- R8: If `dn_valid` is high and `dn_ready` is low, then in the next cycle `dn_valid` is still high and `dn_uop` is unchanged.
- R9: If `dn_ready` is high in two consecutive cycles, and `up_ready` is low in the first of them, then `up_ready` is high in the cycle after the second.
- R10: All 51 payload bits pass through unchanged. Packing, from the most significant bit down: fault (1), tag (6), opcode (7), destination register (7), source A (7), source B (7), immediate (16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| up_valid | input | 1 | Upstream packet is valid |
| up_ready | output | 1 | Link accepts upstream packet (inverse of registered busy) |
| up_uop | input | 51 | Upstream micro-operation payload |
| dn_valid | output | 1 | Downstream packet is valid |
| dn_ready | input | 1 | Downstream can take the packet (low = stall) |
| dn_uop | output | 51 | Downstream micro-operation payload |

## Verification
The link is driven with four input patterns:
- **Back-to-back supply into an always-ready sink.** This separates a correct link from one that inserts spurious busy cycles or adds latency.
- **Continuous supply into a held stall.** This shows whether the in-flight packet is kept or dropped, and whether busy holds the sender.
- **Alternating bubbles, also against a stall.** This shows whether invalid slots leak out or fill the buffer.
- **Long random mix of supply gaps and downstream stalls.** This hits release-and-restall timings that reveal reordering, duplication or loss.

Upstream data is scrambled whenever the link is busy, so that a design sampling it at the wrong time delivers garbage.

// File: rtl/rbl_pkg.sv
package rbl_pkg;
  localparam int TAG_W  = 6;
  localparam int OPC_W  = 7;
  localparam int AREG_W = 7;
  localparam int IMM_W  = 16;

  typedef struct packed {
    logic              flt;
    logic [TAG_W-1:0]  tag;
    logic [OPC_W-1:0]  opc;
    logic [AREG_W-1:0] rd;
    logic [AREG_W-1:0] ra;
    logic [AREG_W-1:0] rb;
    logic [IMM_W-1:0]  imm;
  } uop_t;

  localparam int UOP_W = $bits(uop_t);

  // One channel slot: qualifier plus payload
  typedef struct packed {
    logic vld;
    uop_t uop;
  } slot_t;
endpackage

// File: rtl/rbl_sender.sv
module rbl_sender
  import rbl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  uop_t  in_uop,
  input  logic  busy_seen,
  output logic  in_ready,
  output slot_t ch
);
  // The channel register advances only when the registered busy is low;
  // otherwise the slot already sent stays on the wires.
  assign in_ready = ~busy_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch <= '0;
    end else if (!busy_seen) begin
      ch.vld <= in_valid;
      ch.uop <= in_uop;
    end
  end
endmodule

// File: rtl/rbl_receiver.sv
module rbl_receiver
  import rbl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t ch,
  input  logic  out_ready,
  output logic  out_valid,
  output uop_t  out_uop,
  output logic  busy_q
);
  logic fresh_q;      // channel slot was loaded and not yet consumed
  logic skid_vld;
  uop_t skid_uop;

  logic ch_live, take, ch_used, skid_nxt, fresh_nxt;
  uop_t skid_uop_nxt;

  always_comb begin
    ch_live   = fresh_q & ch.vld;
    out_valid = skid_vld | ch_live;
    out_uop   = skid_vld ? skid_uop : ch.uop;
    take      = out_valid & out_ready;

    skid_nxt     = skid_vld;
    skid_uop_nxt = skid_uop;
    ch_used      = 1'b0;
    if (skid_vld) begin
      // Parked packet goes first; the held channel slot refills the skid.
      if (take) begin
        skid_nxt     = ch_live;
        skid_uop_nxt = ch.uop;
        ch_used      = ch_live;
      end
    end else if (ch_live) begin
      ch_used = 1'b1;
      if (!out_ready) begin
        skid_nxt     = 1'b1;
        skid_uop_nxt = ch.uop;
      end
    end

    // With busy low the sender loads a new slot on this edge.
    fresh_nxt = busy_q ? (fresh_q & ~ch_used) : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh_q  <= 1'b0;
      skid_vld <= 1'b0;
      skid_uop <= '0;
      busy_q   <= 1'b0;
    end else begin
      fresh_q  <= fresh_nxt;
      skid_vld <= skid_nxt;
      skid_uop <= skid_uop_nxt;
      busy_q   <= skid_nxt;   // busy mirrors skid occupancy, one edge late for the sender
    end
  end
endmodule

// File: rtl/busy_skid_link.sv
module busy_skid_link
  import rbl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [UOP_W-1:0] up_uop,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [UOP_W-1:0] dn_uop
);
  slot_t ch;
  logic  busy;
  uop_t  rx_uop;

  rbl_sender u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (up_valid),
    .in_uop    (uop_t'(up_uop)),
    .busy_seen (busy),
    .in_ready  (up_ready),
    .ch        (ch)
  );

  rbl_receiver u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch        (ch),
    .out_ready (dn_ready),
    .out_valid (dn_valid),
    .out_uop   (rx_uop),
    .busy_q    (busy)
  );

  assign dn_uop = rx_uop;
endmodule

// File: rtl/busy_skid_link_chk.sv
module busy_skid_link_chk
  import rbl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             up_valid,
  input logic             up_ready,
  input logic             dn_valid,
  input logic             dn_ready,
  input logic [UOP_W-1:0] dn_uop
);
  logic [2:0] occ;
  logic       acc, del;

  assign acc = up_valid & up_ready;
  assign del = dn_valid & dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + {2'b0, acc} - {2'b0, del};
  end

  // R5: channel plus skid never hold more than two packets
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 3'd2);

  // R7: output only when an accepted packet is outstanding
  p_no_phantom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> occ != 3'd0);

  // R8: stalled output is held
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_uop));

  // R2: a ready sink never causes busy
  p_stream_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    up_ready && dn_ready |=> up_ready);

  // R3: busy rises only after a stalled output
  p_busy_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_ready) |-> $past(dn_valid && !dn_ready));

  // R9: two ready cycles clear busy
  p_recover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !up_ready && dn_ready ##1 dn_ready |=> up_ready);

  // R1: idle state under reset
  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (up_ready || $isunknown(up_ready));
    end
  end
endmodule

bind busy_skid_link busy_skid_link_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .up_valid (up_valid),
  .up_ready (up_ready),
  .dn_valid (dn_valid),
  .dn_ready (dn_ready),
  .dn_uop   (dn_uop)
);

// File: tb/busy_skid_link_tb.sv
module busy_skid_link_tb;
  import rbl_pkg::*;

  localparam int HALF = 4;   // 125 MHz

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             up_valid = 1'b0;
  logic             up_ready;
  logic [UOP_W-1:0] up_uop = '0;
  logic             dn_valid;
  logic             dn_ready = 1'b0;
  logic [UOP_W-1:0] dn_uop;

  busy_skid_link u_dut (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_ready(up_ready), .up_uop(up_uop),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_uop(dn_uop)
  );

  always #HALF clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int n_acc = 0, n_del = 0, n_busy = 0;
  int cyc = 0;
  int src_mode = 0, snk_mode = 0;
  bit lat_chk = 0, done = 0;
  int unsigned seq = 1;
  logic [UOP_W-1:0] exp_q[$];
  int ts_q[$];
  bit hold_pend = 0;
  logic [UOP_W-1:0] hold_uop;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [UOP_W-1:0] pkt(input int unsigned s);
    logic [63:0] t;
    t = {s, s * 32'h9E37_79B1};
    return t[UOP_W-1:0];
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Driver: offers packets, pushes expected items on handshake
  always begin
    @(negedge clk);
    if (!rst_n) up_valid = 1'b0;
    else begin
      case (src_mode)
        0: up_valid = 1'b0;
        1: up_valid = 1'b1;
        2: up_valid = ($urandom_range(0, 3) != 0);
        default: up_valid = ~up_valid;
      endcase
      // R4: scramble data while busy, it must never be taken
      up_uop = up_ready ? pkt(seq) : ~pkt(seq);
      #2;
      if (up_valid && up_ready) begin
        exp_q.push_back(up_uop);
        ts_q.push_back(cyc);
        seq++;
        n_acc++;
      end
    end
  end

  // Sink ready pattern
  always begin
    @(negedge clk);
    case (snk_mode)
      0: dn_ready = 1'b0;
      1: dn_ready = 1'b1;
      default: dn_ready = ($urandom_range(0, 2) != 0);
    endcase
  end

  // Monitor: pops and compares
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (!up_ready) n_busy++;
      if (hold_pend) begin
        chk(dn_valid == 1'b1, "R8 valid held", 64'(dn_valid), 64'd1);
        chk(dn_uop == hold_uop, "R8 data held", 64'(dn_uop), 64'(hold_uop));
      end
      if (dn_valid && dn_ready) begin
        n_del++;
        if (exp_q.size() == 0) chk(1'b0, "R6 extra packet", 64'(dn_uop), 64'd0);
        else begin
          logic [UOP_W-1:0] e;
          int t;
          e = exp_q.pop_front();
          t = ts_q.pop_front();
          chk(dn_uop == e, "R6 R10 order/payload", 64'(dn_uop), 64'(e));
          if (lat_chk) chk(cyc == t + 1, "R2 latency", 64'(cyc), 64'(t + 1));
        end
      end
      hold_pend = dn_valid && !dn_ready;
      hold_uop  = dn_uop;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 64'(cyc), 64'd0);
    finish_run();
  end

  initial begin
    int a0, d0, b0;
    step(4);
    chk(dn_valid == 1'b0, "R1 dn_valid in reset", 64'(dn_valid), 64'd0);
    chk(up_ready == 1'b1, "R1 up_ready in reset", 64'(up_ready), 64'd1);
    rst_n = 1'b1;
    step(1);
    chk(dn_valid == 1'b0, "R1 dn_valid after reset", 64'(dn_valid), 64'd0);
    chk(up_ready == 1'b1, "R1 up_ready after reset", 64'(up_ready), 64'd1);

    // R2: back-to-back into ready sink
    snk_mode = 1; lat_chk = 1; src_mode = 1;
    step(100);
    src_mode = 0;
    step(4);
    lat_chk = 0;
    chk(n_busy == 0, "R2 no busy cycles", 64'(n_busy), 64'd0);
    chk(n_acc > 90, "R2 throughput", 64'(n_acc), 64'd91);

    // R3/R5: held stall with continuous supply
    a0 = n_acc; d0 = n_del;
    snk_mode = 0; src_mode = 1;
    step(20);
    chk(n_acc - a0 == 2, "R5 two accepted into stall", 64'(n_acc - a0), 64'd2);
    chk(up_ready == 1'b0, "R3 busy held during stall", 64'(up_ready), 64'd0);
    chk(dn_valid == 1'b1, "R3 parked packet offered", 64'(dn_valid), 64'd1);
    src_mode = 0; snk_mode = 1;
    step(2);
    chk(up_ready == 1'b1, "R9 busy released", 64'(up_ready), 64'd1);
    step(4);
    // R4: garbage offered while busy must not appear
    chk(n_del - d0 == 2, "R4 R5 only accepted delivered", 64'(n_del - d0), 64'd2);
    chk(exp_q.size() == 0, "R6 stall drained", 64'(exp_q.size()), 64'd0);

    // R7: bubbles against stall, then alternating bubbles
    b0 = n_busy;
    snk_mode = 0; src_mode = 0;
    step(10);
    chk(n_busy == b0, "R7 bubbles cause no busy", 64'(n_busy - b0), 64'd0);
    chk(dn_valid == 1'b0, "R7 bubbles not output", 64'(dn_valid), 64'd0);
    src_mode = 3; snk_mode = 1;
    step(60);
    src_mode = 0;
    step(4);
    chk(exp_q.size() == 0, "R7 alternating drained", 64'(exp_q.size()), 64'd0);
    chk(n_del == n_acc, "R7 deliveries equal accepts", 64'(n_del), 64'(n_acc));

    // R6: random supply and stalls
    src_mode = 2; snk_mode = 2;
    step(3000);
    src_mode = 0; snk_mode = 1;
    step(8);
    chk(exp_q.size() == 0, "R6 random drained", 64'(exp_q.size()), 64'd0);
    chk(n_del == n_acc, "R6 no drop no dup", 64'(n_del), 64'(n_acc));
    chk(n_busy > b0, "R3 random stalls raised busy", 64'(n_busy), 64'(b0 + 1));
    finish_run();
  end
endmodule